// File: doc/BRIEF.md
# Burst SRAM Line Strobe Sequencer

This block drives the control strobes of pipelined synchronous burst SRAMs that hold the data array of a cache. A cache line is four double-words (32 bytes) and always moves as one burst. For each burst the sequencer pulses an address strobe once to load the starting double-word index into the SRAMs. It then pulses an advance strobe to step the SRAM's internal burst counter. The counter walks the line in interleaved sub-block order: beat i touches double-word `start XOR i`. That lets a burst begin at whichever double-word is needed first.

A cache sequencer hands over one request at a time through a valid/ready handshake: direction, starting double-word, and a wait-state setting sampled when the request is accepted. Reads are read hits. The block drives the SRAM output enable and reports each returned double-word on a beat output with no back-pressure, because the SRAMs cannot stall. Writes cover block writes and line fills. Each double-word arrives through a valid/ready beat handshake. The supplier may present beats back to back or with idle clocks between them. On idle clocks the sequencer issues no strobe, so the SRAM burst address stays on the pending double-word.

Top module: `line_burst_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `sram_ads`, `sram_adv`, `sram_oe`, `sram_we`, `wr_ready` and `rd_valid` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the burst ends. A `req_valid` seen while busy is ignored and starts no strobe.
- R3: Every burst asserts `sram_ads` in exactly one cycle. In that cycle `sram_addr` equals the accepted start double-word.
- R4: A read accepted in cycle 0 with zero wait states gives `sram_ads` in cycle 1 and `sram_adv` in cycles 2 to 4. It gives `rd_valid` in cycles 3, 4, 5 and 6 (a 3-1-1-1 pattern), and `req_ready` returns in cycle 7.
- R5: With `cfg_wait` = 1 at acceptance, every read event of R4 happens one cycle later. The data beats keep one-clock spacing. Changing `cfg_wait` during a burst has no effect on that burst.
- R6: Beat i of a burst (i = 0..3) addresses double-word `start XOR i`. This index is shown on `rd_dw` with `rd_valid` for reads, and on `wr_dw` with `wr_ready` for writes.
- R7: `sram_oe` is 1 only during reads, from the `sram_ads` cycle through the last data beat. It is never 1 together with `sram_we`.
- R8: During a write burst `wr_ready` is 1 from the cycle after acceptance until the fourth beat is taken. A cycle with `wr_valid` = 1 drives `sram_we` = 1. The first such beat also drives `sram_ads`; each later beat drives `sram_adv` instead. `req_ready` returns the cycle after the fourth beat.
- R9: A write cycle with `wr_valid` = 0 drives neither `sram_we` nor `sram_adv`, and `wr_dw` keeps the pending double-word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wait | input | 1 | 1 = one extra clock before read data; sampled at request acceptance |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Sequencer idle, can accept a request |
| req_write | input | 1 | 1 = write burst (block write or line fill), 0 = read hit |
| req_start | input | 2 | First (critical) double-word index of the line |
| wr_valid | input | 1 | Write beat present on the SRAM data bus this cycle |
| wr_ready | output | 1 | Sequencer is in a write burst and takes beats |
| wr_dw | output | 2 | Double-word index the next write beat goes to |
| rd_valid | output | 1 | SRAM read data valid this cycle |
| rd_dw | output | 2 | Double-word index of the current read beat |
| sram_ads | output | 1 | Address strobe: load burst start address |
| sram_adv | output | 1 | Advance strobe: step SRAM burst counter |
| sram_addr | output | 2 | Start double-word index presented with the address strobe |
| sram_oe | output | 1 | SRAM data output enable |
| sram_we | output | 1 | SRAM data write enable |

## Verification
A wrong phase counter or a wrong latched wait setting shows at the ports within one cycle. The address strobe or the first `rd_valid` lands a clock early or late against the 3-1-1-1 or 4-1-1-1 window. A corrupted start index or beat counter shows as data from a wrong double-word in the bench's burst SRAM model. That error appears on the first misordered beat and is checked for all four start offsets. A stale write-beat count shows as an advance where an address strobe belongs, or as a burst that ends early or late. The bench reports this by the next `req_ready` cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
  import lsq_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int IDX_W = $clog2(BEATS),
  parameter int PH_W  = $clog2(BEATS + 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_start,
  input  logic             cfg_wait,
  input  logic             wr_valid,
  output seq_state_t       state,
  output logic [IDX_W-1:0] start_q,
  output logic             wait_q,
  output logic [PH_W-1:0]  phase,
  output logic [IDX_W-1:0] wcnt,
  output logic             req_ready
);
  localparam logic [PH_W-1:0]  LAST_PH0 = PH_W'(BEATS + 1);
  localparam logic [IDX_W-1:0] LAST_WR  = IDX_W'(BEATS - 1);

  logic [PH_W-1:0] last_ph;
  assign last_ph   = LAST_PH0 + PH_W'(wait_q);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      start_q <= '0;
      wait_q  <= 1'b0;
      phase   <= '0;
      wcnt    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state   <= req_write ? ST_WRITE : ST_READ;
            start_q <= req_start;
            wait_q  <= cfg_wait;
            phase   <= '0;
            wcnt    <= '0;
          end
        end
        ST_READ: begin
          if (phase == last_ph) state <= ST_IDLE;
          else                  phase <= phase + 1'b1;
        end
        ST_WRITE: begin
          if (wr_valid) begin
            if (wcnt == LAST_WR) state <= ST_IDLE;
            else                 wcnt  <= wcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsq_rd_decode.sv
module lsq_rd_decode #(
  parameter int BEATS = 4,
  parameter int IDX_W = $clog2(BEATS),
  parameter int PH_W  = $clog2(BEATS + 4)
) (
  input  logic             active,
  input  logic             wait_q,
  input  logic [PH_W-1:0]  phase,
  output logic             ads,
  output logic             adv,
  output logic             oe,
  output logic             dvalid,
  output logic [IDX_W-1:0] step
);
  // SRAM is pipelined: data appears two clocks after its address is loaded.
  localparam int PIPE = 2;

  logic [PH_W-1:0] w, first_adv, last_adv, first_dat, last_dat, rel;

  always_comb begin
    w         = PH_W'(wait_q);
    first_adv = w + PH_W'(1);
    last_adv  = w + PH_W'(BEATS - 1);
    first_dat = w + PH_W'(PIPE);
    last_dat  = w + PH_W'(BEATS + PIPE - 1);
    rel       = phase - first_dat;
    ads       = active && (phase == w);
    adv       = active && (phase >= first_adv) && (phase <= last_adv);
    oe        = active && (phase >= w) && (phase <= last_dat);
    dvalid    = active && (phase >= first_dat) && (phase <= last_dat);
    step      = rel[IDX_W-1:0];
  end
endmodule

// File: rtl/lsq_order.sv
module lsq_order #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] step,
  output logic [IDX_W-1:0] dw
);
  assign dw = base ^ step;
endmodule

// File: rtl/line_burst_seq.sv
module line_burst_seq
  import lsq_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wait,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_start,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [IDX_W-1:0] wr_dw,
  output logic             rd_valid,
  output logic [IDX_W-1:0] rd_dw,
  output logic             sram_ads,
  output logic             sram_adv,
  output logic [IDX_W-1:0] sram_addr,
  output logic             sram_oe,
  output logic             sram_we
);
  localparam int PH_W = $clog2(BEATS + 4);

  seq_state_t       state;
  logic [IDX_W-1:0] start_q, wcnt, rd_step;
  logic [PH_W-1:0]  phase;
  logic             wait_q;
  logic             rd_ads, rd_adv, rd_oe, rd_dv;
  logic             in_write, wr_beat;

  lsq_ctrl #(.BEATS(BEATS), .IDX_W(IDX_W), .PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_start(req_start), .cfg_wait(cfg_wait), .wr_valid(wr_valid),
    .state(state), .start_q(start_q), .wait_q(wait_q), .phase(phase),
    .wcnt(wcnt), .req_ready(req_ready)
  );

  lsq_rd_decode #(.BEATS(BEATS), .IDX_W(IDX_W), .PH_W(PH_W)) u_rdec (
    .active(state == ST_READ), .wait_q(wait_q), .phase(phase),
    .ads(rd_ads), .adv(rd_adv), .oe(rd_oe), .dvalid(rd_dv), .step(rd_step)
  );

  lsq_order #(.IDX_W(IDX_W)) u_rd_order (.base(start_q), .step(rd_step), .dw(rd_dw));
  lsq_order #(.IDX_W(IDX_W)) u_wr_order (.base(start_q), .step(wcnt),    .dw(wr_dw));

  assign in_write  = (state == ST_WRITE);
  assign wr_beat   = in_write && wr_valid;
  assign wr_ready  = in_write;
  assign rd_valid  = rd_dv;
  assign sram_addr = start_q;
  assign sram_oe   = rd_oe;
  assign sram_we   = wr_beat;
  assign sram_ads  = rd_ads || (wr_beat && (wcnt == '0));
  assign sram_adv  = rd_adv || (wr_beat && (wcnt != '0));
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wait,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             sram_ads,
  input logic             sram_adv,
  input logic             sram_oe,
  input logic             sram_we
);
  logic accept;
  logic ads_seen;
  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        ads_seen <= 1'b0;
    else if (accept)   ads_seen <= 1'b0;
    else if (sram_ads) ads_seen <= 1'b1;
  end

  assert_one_ads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ads_seen |-> !sram_ads);
  assert_ads_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ads |=> !sram_ads);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_read_ads_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !cfg_wait) |=> sram_ads);
  assert_read_ads_delayed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && cfg_wait) |=> !sram_ads);
  assert_oe_we_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_oe && sram_we));
  assert_data_in_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> sram_oe);
  assert_we_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (wr_valid && wr_ready));
  assert_idle_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |-> (!sram_adv && !sram_we));
endmodule

bind line_burst_seq lsq_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .sram_ads(sram_ads),
  .sram_adv(sram_adv), .sram_oe(sram_oe), .sram_we(sram_we)
);

// File: tb/line_burst_seq_test.sv
module line_burst_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wait = 1'b0, req_valid = 1'b0, req_write = 1'b0, wr_valid = 1'b0;
  logic [1:0] req_start = '0;
  logic       req_ready, wr_ready, rd_valid, sram_ads, sram_adv, sram_oe, sram_we;
  logic [1:0] wr_dw, rd_dw, sram_addr;
  logic [15:0] wdata = '0;

  int checks = 0, errors = 0;
  logic [15:0] expv [4];

  always #5 clk = ~clk;

  line_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_start(req_start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dw(wr_dw), .rd_valid(rd_valid),
    .rd_dw(rd_dw), .sram_ads(sram_ads), .sram_adv(sram_adv), .sram_addr(sram_addr),
    .sram_oe(sram_oe), .sram_we(sram_we)
  );

  // Behavioural pipelined burst SRAM, interleaved counter.
  logic [15:0] mem [4];
  logic [1:0]  m_base = '0, m_cnt = '0;
  logic [15:0] m_dout = '0;
  always @(posedge clk) begin
    m_dout <= mem[m_base ^ m_cnt];
    if (sram_ads) begin
      m_base <= sram_addr;
      m_cnt  <= '0;
      if (sram_we) mem[sram_addr] <= wdata;
    end else if (sram_adv) begin
      m_cnt <= m_cnt + 2'd1;
      if (sram_we) mem[m_base ^ (m_cnt + 2'd1)] <= wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input int w, input int s, input int pat, input int round);
    int b = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_start = 2'(s); cfg_wait = 1'(w);
    #1 chk(req_ready == 1, "R2 write accept ready", req_ready, 1);
    for (int k = 1; k < 60 && b < 4; k++) begin
      @(negedge clk);
      req_valid = (k < 3); req_write = 0; cfg_wait = 1'(~w);
      wr_valid = ((k % (pat + 1)) == 0);
      wdata = 16'hA000 | 16'(round << 4) | 16'(s ^ b);
      #1;
      chk(wr_ready == 1 && req_ready == 0, "R8 wr_ready during burst", wr_ready, 1);
      chk(wr_dw == 2'(s ^ b), "R6 write beat order", wr_dw, s ^ b);
      chk(sram_oe == 0, "R7 no oe in write", sram_oe, 0);
      if (wr_valid) begin
        chk(sram_we == 1, "R8 we on beat", sram_we, 1);
        chk(sram_ads == (b == 0), "R8 ads on first beat", sram_ads, b == 0);
        chk(sram_adv == (b != 0), "R8 adv on later beats", sram_adv, b != 0);
        if (b == 0) chk(sram_addr == 2'(s), "R3 start address", sram_addr, s);
        expv[s ^ b] = wdata;
        b++;
      end else begin
        chk(sram_we == 0 && sram_adv == 0 && sram_ads == 0, "R9 idle beat no strobe",
            {sram_we, sram_adv, sram_ads}, 0);
      end
    end
    @(negedge clk);
    wr_valid = 0; req_valid = 0;
    #1 chk(req_ready == 1 && wr_ready == 0, "R8 ready after fourth beat", req_ready, 1);
  endtask

  task automatic do_read(input int w, input int s);
    int i;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_start = 2'(s); cfg_wait = 1'(w);
    #1 chk(req_ready == 1, "R2 read accept ready", req_ready, 1);
    for (int k = 1; k <= w + 7; k++) begin
      @(negedge clk);
      req_valid = (k <= 3); req_write = 1; cfg_wait = 1'(~w);
      #1;
      chk(sram_ads == (k == 1 + w), (w != 0) ? "R5 ads timing" : "R4 ads timing",
          sram_ads, k == 1 + w);
      if (k == 1 + w) chk(sram_addr == 2'(s), "R3 read start address", sram_addr, s);
      chk(sram_adv == (k >= 2 + w && k <= 4 + w), (w != 0) ? "R5 adv timing" : "R4 adv timing",
          sram_adv, k >= 2 + w && k <= 4 + w);
      chk(rd_valid == (k >= 3 + w && k <= 6 + w), (w != 0) ? "R5 data timing" : "R4 data timing",
          rd_valid, k >= 3 + w && k <= 6 + w);
      chk(sram_oe == (k >= 1 + w && k <= 6 + w), "R7 oe window", sram_oe, k >= 1 + w && k <= 6 + w);
      chk(sram_we == 0, "R7 no we in read", sram_we, 0);
      chk(req_ready == (k == w + 7), "R2 busy until burst end", req_ready, k == w + 7);
      if (k >= 3 + w && k <= 6 + w) begin
        i = k - 3 - w;
        chk(rd_dw == 2'(s ^ i), "R6 read beat order", rd_dw, s ^ i);
        chk(m_dout == expv[s ^ i], "R6 read data", m_dout, expv[s ^ i]);
      end
    end
    req_valid = 0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4; a++) begin mem[a] = 16'h0; expv[a] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    chk({sram_ads, sram_adv, sram_oe, sram_we, wr_ready, rd_valid} == 6'b0,
        "R1 reset strobes", {sram_ads, sram_adv, sram_oe, sram_we, wr_ready, rd_valid}, 0);
    for (int w = 0; w < 2; w++)
      for (int ws = 0; ws < 4; ws++) begin
        do_write(w, ws, (ws + w) % 3, w * 4 + ws);
        for (int rs = 0; rs < 4; rs++) do_read(w, rs);
      end
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule